// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block carries bytes from a processor bus out to two peripherals, one per channel. A processor write aimed at a channel captures the data byte into that channel's output register. In the same clock cycle it pulls the channel's active-low "data waiting" line low. The peripheral takes the byte and answers with a low pulse on its active-low acknowledge line. The falling half of that pulse releases the waiting line. The rising half raises the channel's interrupt request, but only if that channel's interrupt enable is set. This tells the processor that the next byte may be sent. The next processor write to the channel clears the request.

The interrupt enables have no address of their own. They are set and cleared through a single-bit command written to the command address. A status byte on a dedicated output packs the waiting lines, the enables and the requests of both channels into fixed bit positions, so that polling software can read them.

Top module: `strobed_out_port`

## Requirements
- R1: While rst_n is low at a clock edge, both obf_n bits go to 1, both intr bits go to 0, both interrupt enables go to 0, and dout_a and dout_b go to 0.
- R2: A write is taken at the first clock edge where wr_n is low after an edge where it was high, with cs_n low. At that edge the byte on din is captured by the channel that addr selects (0 = channel A, 1 = channel B), and that channel's obf_n goes to 0. The other channel does not change. addr = 2 writes nothing.
- R3: After ack_n of a channel falls, its obf_n returns to 1 at the third rising clock edge, because of two synchronizer stages and one edge-detect stage.
- R4: At the third clock edge after ack_n of a channel rises, intr of that channel goes to 1, provided that its obf_n is 1 and its interrupt enable is 1.
- R5: With the interrupt enable of a channel at 0, a full acknowledge pulse leaves intr of that channel at 0.
- R6: A taken write to a channel clears that channel's intr. If a write and a detected acknowledge rise reach the same channel at the same edge, the write wins: intr is 0 and obf_n is 0.
- R7: A taken write with addr = 3 and din[7] = 0 is a bit command. din[3:1] is the bit index and din[0] is the new value. Index 6 sets the enable of channel A and index 2 sets the enable of channel B. Other indices, and any word with din[7] = 1, change nothing.
- R8: The status byte reads: bit 7 = obf_n of A, bit 6 = enable A, bit 3 = intr A, bit 2 = enable B, bit 1 = obf_n of B, bit 0 = intr B. Bits 5 and 4 read 0.
- R9: A channel's output byte holds through the whole acknowledge handshake and changes only on a taken write to that channel.
- R10: Holding wr_n low for many cycles performs one write only. An acknowledge that arrives while the strobe stays low releases obf_n normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low qualifier that selects this block for a write |
| wr_n | input | 1 | Active-low processor write strobe, sampled on clk |
| addr | input | 2 | Write target: 0 channel A, 1 channel B, 2 unused, 3 command |
| din | input | 8 | Processor data byte |
| ack_n | input | 2 | Active-low acknowledges from the peripherals (bit 0 = A, bit 1 = B) |
| dout_a | output | 8 | Output byte of channel A |
| dout_b | output | 8 | Output byte of channel B |
| obf_n | output | 2 | Active-low data-waiting lines (bit 0 = A, bit 1 = B) |
| intr | output | 2 | Interrupt requests (bit 0 = A, bit 1 = B) |
| status | output | 8 | Packed status byte |

## Verification
The hardest case to reach from the ports is a processor write and a synchronized acknowledge rise that hit the same channel at the same clock edge. Reaching it needs the strobe edge placed to land exactly on the edge-detect stage's output. The stimulus raises ack_n, waits two clock edges, and then drops wr_n so that the write is taken at the third edge, the same edge where the rise is seen. A held strobe combined with a full acknowledge pulse covers the one-write-per-strobe rule. Bit commands with a foreign index, and mode-set words, are each followed by a status comparison to show that nothing moved.

// File: rtl/spo_pkg.sv
// Shared constants for the strobed output port: write targets, enable bit
// indices of the bit command, and status byte positions.
package spo_pkg;
    localparam logic [1:0] TGT_A   = 2'd0;
    localparam logic [1:0] TGT_B   = 2'd1;
    localparam logic [1:0] TGT_C   = 2'd2;
    localparam logic [1:0] TGT_CMD = 2'd3;

    localparam int EN_BIT_A = 6;
    localparam int EN_BIT_B = 2;

    localparam int ST_OBF_A  = 7;
    localparam int ST_INTE_A = 6;
    localparam int ST_INTR_A = 3;
    localparam int ST_INTE_B = 2;
    localparam int ST_OBF_B  = 1;
    localparam int ST_INTR_B = 0;
endpackage

// File: rtl/spo_ack_sync.sv
// Brings an asynchronous active-low acknowledge into the clock domain through
// STAGES flip-flops and flags its falling and rising edges for one cycle.
// Assumes the idle level is high; reset fills the chain with ones so that no
// edge is reported when reset ends.
module spo_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    output logic ack_fall_o,
    output logic ack_rise_o
);
    logic [STAGES:0] pipe_q;

    // Shift the acknowledge through the synchronizer and the edge register.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], ack_n_i};
    end

    assign ack_fall_o = !pipe_q[STAGES-1] &&  pipe_q[STAGES];
    assign ack_rise_o =  pipe_q[STAGES-1] && !pipe_q[STAGES];
endmodule

// File: rtl/spo_bsr.sv
// Holds one interrupt-enable flag that the single-bit command updates.
// Assumes cmd_fire_i already means a taken write to the command address.
// A command with the mode flag set, or one with another bit index, is ignored.
module spo_bsr #(
    parameter int IDX_W  = 3,
    parameter int EN_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_fire_i,
    input  logic             mode_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             val_i,
    output logic             inte_o
);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(EN_BIT);

    logic hit;
    assign hit = cmd_fire_i && !mode_i && (idx_i == MY_IDX);

    // Update the enable flag when a matching bit command arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)   inte_o <= 1'b0;
        else if (hit) inte_o <= val_i;
    end

    // R7
    inte_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inte_o) |-> $past(cmd_fire_i && !mode_i && idx_i == MY_IDX));
endmodule

// File: rtl/spo_channel.sv
// One output channel: latches the written byte, drives the active-low
// data-waiting line, and raises the interrupt request when the acknowledge ends.
// Assumes the acknowledge edges arrive already synchronized. A write takes
// priority over an acknowledge edge in the same cycle.
module spo_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ack_fall_i,
    input  logic              ack_rise_i,
    input  logic              inte_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              obf_n_o,
    output logic              intr_o
);
    // Data latch, buffer-full flag and request flag, with the write first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o  <= '0;
            obf_n_o <= 1'b1;
            intr_o  <= 1'b0;
        end else if (wr_fire_i) begin
            dout_o  <= din_i;
            obf_n_o <= 1'b0;
            intr_o  <= 1'b0;
        end else begin
            if (ack_fall_i)
                obf_n_o <= 1'b1;
            if (ack_rise_i && obf_n_o && inte_i)
                intr_o <= 1'b1;
        end
    end

    // R2
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire_i |=> (!obf_n_o && dout_o == $past(din_i)));

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_o) |-> $past(wr_fire_i));

    // R3
    obf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obf_n_o) |-> $past(ack_fall_i));

    // R4
    intr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_o) |-> $past(inte_i && obf_n_o && ack_rise_i));

    // R6
    intr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_o) |-> $past(wr_fire_i));
endmodule

// File: rtl/strobed_out_port.sv
// Two-channel strobed output port. Detects the processor write edge, routes
// it to a channel or to the bit command, synchronizes each acknowledge, and
// packs the status byte. Assumes wr_n, cs_n, addr and din are synchronous to
// clk, and that ack_n may be asynchronous.
module strobed_out_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        ack_n,
    output logic [DATA_W-1:0] dout_a,
    output logic [DATA_W-1:0] dout_b,
    output logic [1:0]        obf_n,
    output logic [1:0]        intr,
    output logic [7:0]        status
);
    import spo_pkg::*;

    localparam int NCH   = 2;
    localparam int IDX_W = $clog2(DATA_W);

    logic              wr_q;
    logic              wr_take;
    logic              cmd_fire;
    logic [NCH-1:0]    inte;
    logic [DATA_W-1:0] dout_w [NCH];

    // Remember the previous strobe level so that only its falling edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    assign wr_take  = wr_q && !wr_n && !cs_n;
    assign cmd_fire = wr_take && (addr == TGT_CMD);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int          EN_BIT = (g == 0) ? EN_BIT_A : EN_BIT_B;
        localparam logic [1:0]  MY_TGT = (g == 0) ? TGT_A : TGT_B;
        logic fall_w, rise_w;

        spo_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .ack_n_i    (ack_n[g]),
            .ack_fall_o (fall_w),
            .ack_rise_o (rise_w)
        );

        spo_bsr #(.IDX_W(IDX_W), .EN_BIT(EN_BIT)) u_bsr (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_fire_i (cmd_fire),
            .mode_i     (din[DATA_W-1]),
            .idx_i      (din[IDX_W:1]),
            .val_i      (din[0]),
            .inte_o     (inte[g])
        );

        spo_channel #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_fire_i  (wr_take && (addr == MY_TGT)),
            .din_i      (din),
            .ack_fall_i (fall_w),
            .ack_rise_i (rise_w),
            .inte_i     (inte[g]),
            .dout_o     (dout_w[g]),
            .obf_n_o    (obf_n[g]),
            .intr_o     (intr[g])
        );
    end

    assign dout_a = dout_w[0];
    assign dout_b = dout_w[1];

    // Pack the status byte; the two general-purpose positions read zero.
    always_comb begin
        status            = '0;
        status[ST_OBF_A]  = obf_n[0];
        status[ST_INTE_A] = inte[0];
        status[ST_INTR_A] = intr[0];
        status[ST_INTE_B] = inte[1];
        status[ST_OBF_B]  = obf_n[1];
        status[ST_INTR_B] = intr[1];
    end

    // R10
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |=> ($stable(dout_a) && $stable(dout_b)));

    // R2
    port_c_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == TGT_C || cs_n) |=> ($stable(dout_a) && $stable(dout_b)));
endmodule

// File: tb/strobed_out_port_test.sv
module strobed_out_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [1:0] ack_n = 2'b11;
    logic [7:0] dout_a, dout_b, status;
    logic [1:0] obf_n, intr;

    always #4 clk = ~clk;

    strobed_out_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .din(din), .ack_n(ack_n), .dout_a(dout_a), .dout_b(dout_b),
        .obf_n(obf_n), .intr(intr), .status(status)
    );

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic [7:0] da;
        logic [7:0] db;
        logic [1:0] ob;
        logic [1:0] ir;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    logic [7:0] m_da = 0, m_db = 0;
    logic [1:0] m_obf = 2'b11, m_inte = 2'b00, m_intr = 2'b00;

    // R8 expected status layout
    function automatic logic [7:0] exp_status();
        return {m_obf[0], m_inte[0], 2'b00, m_intr[0], m_inte[1], m_obf[1], m_intr[1]};
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.tag = tag; e.st = exp_status(); e.da = m_da; e.db = m_db;
        e.ob = m_obf; e.ir = m_intr;
        q.push_back(e);
        -> chk_ev;
    endtask

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (status !== e.st || dout_a !== e.da || dout_b !== e.db ||
                    obf_n !== e.ob || intr !== e.ir) begin
                    bad++;
                    $display("FAIL %s: st/da/db/obf/intr act=%h/%h/%h/%b/%b exp=%h/%h/%h/%b/%b",
                             e.tag, status, dout_a, dout_b, obf_n, intr,
                             e.st, e.da, e.db, e.ob, e.ir);
                end
            end
        end
    end

    // Apply the strobe and the model update for R2, R6 and R7 writes.
    function automatic void model_write(logic [1:0] a, logic [7:0] d);
        if (a == 2'd0) begin m_da = d; m_obf[0] = 1'b0; m_intr[0] = 1'b0; end
        if (a == 2'd1) begin m_db = d; m_obf[1] = 1'b0; m_intr[1] = 1'b0; end
        if (a == 2'd3 && !d[7]) begin
            if (d[3:1] == 3'd6) m_inte[0] = d[0];
            if (d[3:1] == 3'd2) m_inte[1] = d[0];
        end
    endfunction

    task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
        cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        model_write(a, d);
        @(negedge clk);
    endtask

    task automatic ack_pulse(int ch);
        ack_n[ch] = 1'b0;
        repeat (4) @(negedge clk);
        m_obf[ch] = 1'b1;
        ack_n[ch] = 1'b1;
        repeat (4) @(negedge clk);
        if (m_inte[ch]) m_intr[ch] = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 R8 reset state");

        cpu_wr(2'd0, 8'h5A);  push("R2 write channel A");
        cpu_wr(2'd1, 8'hC3);  push("R2 write channel B, A untouched");
        cpu_wr(2'd2, 8'hFF);  push("R2 addr 2 writes nothing");
        cpu_wr(2'd3, 8'h0D);  push("R7 enable A via index 6");
        cpu_wr(2'd3, 8'h09);  push("R7 index 4 ignored");
        cpu_wr(2'd3, 8'h8C);  push("R7 mode-flag word ignored");

        // R3 latency on channel A
        ack_n[0] = 1'b0;
        repeat (2) @(negedge clk);
        push("R3 obf_n still low after two edges");
        @(negedge clk);
        m_obf[0] = 1'b1;
        push("R3 obf_n high at third edge");
        @(negedge clk);
        ack_n[0] = 1'b1;
        repeat (2) @(negedge clk);
        push("R4 intr A not yet after two edges");
        @(negedge clk);
        m_intr[0] = 1'b1;
        push("R4 R9 intr A set, data held");

        cpu_wr(2'd0, 8'h11);  push("R6 write clears intr A");

        ack_pulse(1);         push("R5 enable B off, no intr B");
        cpu_wr(2'd3, 8'h05);  push("R7 enable B via index 2");
        cpu_wr(2'd1, 8'h7E);
        ack_pulse(1);         push("R4 intr B after acknowledge");

        // R6 write and acknowledge rise at the same edge on channel A
        cpu_wr(2'd0, 8'h22);
        ack_n[0] = 1'b0;
        repeat (4) @(negedge clk);
        ack_n[0] = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b0; addr = 2'd0; din = 8'h33; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        m_da = 8'h33; m_obf[0] = 1'b0; m_intr[0] = 1'b0;
        push("R6 write wins over same-edge rise");
        repeat (4) @(negedge clk);
        push("R6 intr A stays clear afterwards");

        // R10 held strobe
        cs_n = 1'b0; addr = 2'd0; din = 8'h44; wr_n = 1'b0;
        @(negedge clk);
        m_da = 8'h44; m_obf[0] = 1'b0; m_intr[0] = 1'b0;
        din = 8'h55;
        ack_pulse(0);
        push("R10 held strobe writes once, ack releases");
        wr_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        push("R10 release of held strobe writes nothing");

        cpu_wr(2'd3, 8'h0C);  push("R7 disable A via index 6");
        cpu_wr(2'd0, 8'h66);
        ack_pulse(0);         push("R5 enable A off, no intr A");

        #1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule